// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt sources and a processor core and decides, every clock, whether one of the pending requests may interrupt the work currently running. Each source has a dedicated request input and a dedicated acknowledge output, and each source carries a fixed level. The controller keeps a running processor priority together with a global interrupt enable bit. A request can win only if its source is enabled, the global enable is set, and the source's level lies strictly above the running priority.

When a request is accepted, the controller pulses that source's acknowledge for one cycle, raises the running priority to the source's level and clears the global enable. The old priority is pushed onto a small stack. Software running the service routine can set the global enable again to allow nesting by higher-level sources. A return-from-service pulse pops the saved priority and sets the global enable again, so service routines nest and unwind in order.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the running priority is 0, the global enable is 0, all source enables are 0, no acknowledge is asserted, and the overflow flag is 0.
- R2: Source i has level i+1, so levels run from 1 to 8, and the running priority is a 4-bit value where 0 means normal program execution. A request is accepted only when its level is strictly greater than the running priority.
- R3: On acceptance the running priority becomes the accepted source's level. Priority and acknowledge both change on the clock edge that samples the request.
- R4: The acknowledge vector is one-hot or zero. An acknowledge lasts exactly one cycle, even if the request stays high.
- R5: A request is accepted only while the global enable is 1, and an acceptance clears the global enable.
- R6: A source takes part only while its enable bit is 1. A write on the enable port replaces all enable bits, and the enable bits can be read back on an output.
- R7: A return-from-service pulse sets the global enable and restores the most recently saved priority. If the stack is empty, the priority is left unchanged.
- R8: A status write loads the running priority from bits 3:0 and the global enable from bit 4 of the write data. In the same cycle, return-from-service has precedence over a status write, and a status write has precedence over an acceptance, which is then deferred.
- R9: The priority stack is 4 deep. A push onto a full stack is dropped, which leaves the saved entries as they were, and it sets an overflow flag that stays set until reset.
- R10: When several requests are eligible in the same cycle, the one with the highest level is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 8 | Request line per source |
| irq_ack | output | 8 | One-cycle acknowledge per source |
| en_wr | input | 1 | Load source enable bits |
| en_wdata | input | 8 | New source enable bits |
| src_en | output | 8 | Current source enable bits |
| ps_wr | input | 1 | Status write strobe |
| ps_wdata | input | 5 | Bit 4 global enable, bits 3:0 priority |
| rfs | input | 1 | Return-from-service pulse |
| cur_prio | output | 4 | Running processor priority |
| gie | output | 1 | Global interrupt enable |
| ovf | output | 1 | Sticky stack overflow flag |

## Verification
A table of request patterns is applied, each paired with an enable mask and a starting priority. The patterns include a single low source, the highest and lowest sources together, a request level equal to the running priority, requests masked by their enables, and a running priority at its maximum. Each pattern separates the strict-greater comparison, the highest-level choice and the enable gating from one another. Directed sequences then build a two-deep nesting and unwind it past an empty stack, hold all requests with the global enable off, and drive five nested acceptances. The last sequence shows that the overflowing push is dropped, because the first pop after it returns the priority saved by the fourth push.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

  // Level carried by source number idx; level 0 is reserved for normal execution.
  function automatic int level_of(input int idx);
    return idx + 1;
  endfunction

  // Acceptance test: a candidate level must lie strictly above the running priority.
  function automatic bit beats(input int lvl, input int cur);
    return lvl > cur;
  endfunction

endpackage

// File: rtl/nest_irq_elig.sv
module nest_irq_elig #(
  parameter int NSRC = 8,
  parameter int PW   = 4
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  input  logic            gie,
  input  logic [PW-1:0]   cur_prio,
  output logic [NSRC-1:0] elig
);
  import nest_irq_pkg::*;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int LVL = level_of(i);
    logic above;
    assign above   = beats(LVL, int'(cur_prio));
    assign elig[i] = req[i] & en[i] & gie & above;
  end

endmodule

// File: rtl/nest_irq_pick.sv
module nest_irq_pick #(
  parameter int NSRC = 8,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] elig,
  output logic [NSRC-1:0] onehot,
  output logic [IW-1:0]   idx,
  output logic            any
);

  // Levels rise with the source index, so the highest set index wins.
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    onehot = '0;
    if (any) onehot[idx] = 1'b1;
  end

endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);

  logic [W-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign top   = empty ? '0 : mem[cnt - 1'b1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end else if (push && !full) begin
      mem[cnt] <= din;
      cnt      <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NSRC  = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(NSRC + 1),
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  output logic [NSRC-1:0] irq_ack,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  output logic [NSRC-1:0] src_en,
  input  logic            ps_wr,
  input  logic [PW:0]     ps_wdata,
  input  logic            rfs,
  output logic [PW-1:0]   cur_prio,
  output logic            gie,
  output logic            ovf
);
  import nest_irq_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [NSRC-1:0] elig_w;
  logic [NSRC-1:0] win_oh_w;
  logic [IW-1:0]   win_idx_w;
  logic            any_w;
  logic            accept_w;
  logic            pop_w;
  logic            push_full_w;
  logic [PW-1:0]   win_lvl_w;
  logic [PW-1:0]   saved_w;
  logic            stk_empty_w;
  logic            stk_full_w;

  nest_irq_elig #(.NSRC(NSRC), .PW(PW)) u_elig (
    .req      (irq_req),
    .en       (src_en),
    .gie      (gie),
    .cur_prio (cur_prio),
    .elig     (elig_w)
  );

  nest_irq_pick #(.NSRC(NSRC)) u_pick (
    .elig   (elig_w),
    .onehot (win_oh_w),
    .idx    (win_idx_w),
    .any    (any_w)
  );

  assign win_lvl_w   = PW'(level_of(int'(win_idx_w)));
  assign accept_w    = any_w && !rfs && !ps_wr;
  assign pop_w       = rfs;
  assign push_full_w = accept_w && stk_full_w;

  nest_irq_stack #(.DEPTH(DEPTH), .W(PW)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept_w),
    .pop   (pop_w),
    .din   (cur_prio),
    .top   (saved_w),
    .empty (stk_empty_w),
    .full  (stk_full_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_prio <= '0;
      gie      <= 1'b0;
    end else if (rfs) begin
      gie <= 1'b1;
      if (!stk_empty_w) cur_prio <= saved_w;
    end else if (ps_wr) begin
      gie      <= ps_wdata[PW];
      cur_prio <= ps_wdata[PW-1:0];
    end else if (accept_w) begin
      gie      <= 1'b0;
      cur_prio <= win_lvl_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_ack <= '0;
      src_en  <= '0;
      ovf     <= 1'b0;
    end else begin
      irq_ack <= accept_w ? win_oh_w : '0;
      if (en_wr) src_en <= en_wdata;
      if (push_full_w) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
  parameter int NSRC = 8,
  parameter int PW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_req,
  input logic [NSRC-1:0] irq_ack,
  input logic [NSRC-1:0] src_en,
  input logic            rfs,
  input logic [PW-1:0]   cur_prio,
  input logic            gie,
  input logic            ovf,
  input logic            accept_w
);

  logic [PW-1:0] ack_lvl;
  always_comb begin
    ack_lvl = '0;
    for (int i = 0; i < NSRC; i++) if (irq_ack[i]) ack_lvl = PW'(i + 1);
  end

  a_r4_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));

  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |=> (irq_ack == '0));

  a_r2_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> (cur_prio > $past(cur_prio)));

  a_r3_prio_is_level: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> (cur_prio == ack_lvl));

  a_r5_gie_needed_and_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> (!gie && $past(gie)));

  a_r6_enabled_request: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> $past(|(irq_req & src_en)));

  a_r7_rfs_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    rfs |=> gie);

  a_r8_rfs_blocks_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rfs |-> !accept_w);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.NSRC(NSRC), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_req  (irq_req),
  .irq_ack  (irq_ack),
  .src_en   (src_en),
  .rfs      (rfs),
  .cur_prio (cur_prio),
  .gie      (gie),
  .ovf      (ovf),
  .accept_w (accept_w)
);

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
  localparam int NSRC = 8;
  localparam int PW   = 4;
  localparam int NVEC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0, irq_ack, en_wdata = '0, src_en;
  logic en_wr = 1'b0, ps_wr = 1'b0, rfs = 1'b0;
  logic [PW:0] ps_wdata = '0;
  logic [PW-1:0] cur_prio;
  logic gie, ovf;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  nest_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .en_wr(en_wr), .en_wdata(en_wdata), .src_en(src_en),
    .ps_wr(ps_wr), .ps_wdata(ps_wdata), .rfs(rfs),
    .cur_prio(cur_prio), .gie(gie), .ovf(ovf)
  );

  // Entry: {req[8], en[8], start_prio[4], exp_ack[8], exp_prio[4]}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h01, 8'hFF, 4'd0, 8'h01, 4'd1},  // R3 single low source
    {8'h81, 8'hFF, 4'd0, 8'h80, 4'd8},  // R10 highest of two
    {8'h14, 8'hFF, 4'd3, 8'h10, 4'd5},  // R2 above running priority
    {8'h04, 8'hFF, 4'd3, 8'h00, 4'd3},  // R2 equal level refused
    {8'hF0, 8'h3F, 4'd0, 8'h20, 4'd6},  // R6 masked sources skipped
    {8'hFF, 8'h00, 4'd0, 8'h00, 4'd0},  // R6 all disabled
    {8'h08, 8'hFF, 4'd8, 8'h00, 4'd8},  // R2 priority at maximum
    {8'h02, 8'h02, 4'd1, 8'h02, 4'd2}   // R2 one level above
  };

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    irq_req = '0; en_wr = 0; ps_wr = 0; rfs = 0;
    rst_n = 0; cyc(); rst_n = 1; cyc();
  endtask

  task automatic set_en(input logic [NSRC-1:0] v);
    en_wr = 1; en_wdata = v; cyc(); en_wr = 0;
  endtask

  task automatic set_ps(input logic g, input logic [PW-1:0] p);
    ps_wr = 1; ps_wdata = {g, p}; cyc(); ps_wr = 0;
  endtask

  task automatic pulse_rfs();
    rfs = 1; cyc(); rfs = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 prio", 32'(cur_prio), 0);
    chk("R1 gie", 32'(gie), 0);
    chk("R1 en", 32'(src_en), 0);
    chk("R1 ack", 32'(irq_ack), 0);
    chk("R1 ovf", 32'(ovf), 0);

    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      set_en(VEC[v][31:24] == 8'h00 ? 8'h00 : VEC[v][23:16]);
      set_en(VEC[v][23:16]);
      chk("R6 readback", 32'(src_en), 32'(VEC[v][23:16]));
      set_ps(1'b1, VEC[v][15:12]);
      irq_req = VEC[v][31:24];
      cyc();
      chk($sformatf("R2/R3/R10 vec%0d ack", v), 32'(irq_ack), 32'(VEC[v][11:4]));
      chk($sformatf("R3 vec%0d prio", v), 32'(cur_prio), 32'(VEC[v][3:0]));
      cyc();
      chk($sformatf("R4 vec%0d ack drops", v), 32'(irq_ack), 0);
      irq_req = '0;
    end

    // R5: global enable off holds all requests
    do_reset();
    set_en(8'hFF);
    set_ps(1'b0, 4'd0);
    irq_req = 8'hFF; cyc(); cyc();
    chk("R5 no ack while gie=0", 32'(irq_ack), 0);
    chk("R5 prio kept", 32'(cur_prio), 0);
    irq_req = '0;

    // R8 precedence: status write defers acceptance
    set_ps(1'b1, 4'd0);
    irq_req = 8'h01; ps_wr = 1; ps_wdata = {1'b1, 4'd0}; cyc(); ps_wr = 0;
    chk("R8 ps_wr defers ack", 32'(irq_ack), 0);
    cyc();
    chk("R8 deferred ack", 32'(irq_ack), 32'h01);
    irq_req = '0;

    // Nesting R5 R7
    do_reset();
    set_en(8'hFF);
    set_ps(1'b1, 4'd0);
    irq_req = 8'h04; cyc(); irq_req = '0;
    chk("R3 nest first prio", 32'(cur_prio), 3);
    chk("R5 gie cleared", 32'(gie), 0);
    set_ps(1'b1, 4'd3);
    irq_req = 8'h40; cyc(); irq_req = '0;
    chk("R3 nest second prio", 32'(cur_prio), 7);
    chk("R4 nest second ack", 32'(irq_ack), 32'h40);
    pulse_rfs();
    chk("R7 pop to 3", 32'(cur_prio), 3);
    chk("R7 gie set", 32'(gie), 1);
    pulse_rfs();
    chk("R7 pop to 0", 32'(cur_prio), 0);
    set_ps(1'b0, 4'd2);
    pulse_rfs();
    chk("R7 empty pop keeps prio", 32'(cur_prio), 2);
    chk("R7 empty pop sets gie", 32'(gie), 1);

    // R9 overflow
    do_reset();
    set_en(8'hFF);
    set_ps(1'b1, 4'd0);
    for (int k = 0; k < 5; k++) begin
      irq_req = NSRC'(1) << k; cyc(); irq_req = '0;
      if (k == 3) chk("R9 no ovf at four", 32'(ovf), 0);
      set_ps(1'b1, PW'(k + 1));
    end
    chk("R9 ovf set", 32'(ovf), 1);
    chk("R9 prio after five", 32'(cur_prio), 5);
    pulse_rfs();
    chk("R9 dropped push, pop gives 3", 32'(cur_prio), 3);
    cyc();
    chk("R9 ovf sticky", 32'(ovf), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule